// File: doc/BRIEF.md
# Layered-decoder processor sequencer

This block is the local sequencer for one processor stage in a pipelined decoder for low-density parity-check convolutional codes whose parity-check structure repeats every three check nodes. The previous stage presents a one-cycle strobe each time a new posterior message is shifted in. The sequencer counts those strobes to find where each code-bit group ends. The last bit of a group is the parity bit. When the parity strobe arrives, the sequencer runs one check node across three cycles, one for each delay factor.

For every check node it produces a delay-factor index, a check-polynomial index and a posterior-memory address. It also gives a flag that marks the first pass in the layer, a read strobe and a write strobe for the posterior memories, and a mask that enables only the code-bit lanes the current rate needs. A strobe that arrives while a check node is still running is dropped and reported on a sticky error output.

The state machine has four states. In IDLE it accepts strobes. A parity strobe moves IDLE to DF0. The machine then always steps DF0 to DF1, DF1 to DF2, and DF2 back to IDLE. These three steps are fixed: one per cycle, with no condition.

Top module: `ldcc_proc_ctrl`

## Requirements
- R1: After reset the outputs take these values. delay_idx, poly_idx and mem_addr are 0. first_pass, mem_rd, mem_wr and overrun_err are low. lane_en is 5'b10001.
- R2: Without an accepted parity strobe, the sequencer stays in IDLE. In IDLE, delay_idx is 0 and mem_rd is low. Systematic strobes only advance the group position.
- R3: An accepted parity strobe starts a check node in the next cycle. delay_idx is then 0, 1 and 2 in three consecutive cycles, with mem_rd high in all three. The sequencer then returns to IDLE.
- R4: poly_idx advances by one after the cycle in which delay_idx is 2 with mem_rd high. It follows 0, 1, 2, 0 and changes at no other time.
- R5: mem_addr advances by one together with poly_idx. It wraps from 227 to 0.
- R6: A code-bit group has code_rate+2 accepted strobes. code_rate is encoded 0 for 1/2, 1 for 2/3, 2 for 3/4 and 3 for 4/5. The last strobe of the group is the parity strobe. code_rate is sampled only on the first strobe of a group, and a change during the group has no effect.
- R7: lane_en bit 4 is the parity lane and is always high. Bit i (0 to 3) is systematic lane Xi. It is high exactly when i is at most the code_rate latched for the current group.
- R8: first_pass is high only in the cycle in which delay_idx is 0 during an active check node.
- R9: mem_wr is high exactly one cycle after each cycle in which mem_rd is high.
- R10: A strobe that arrives while a check node is active is ignored. It does not change the group position. overrun_err is set and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_valid | input | 1 | One-cycle strobe: a new posterior message was shifted in |
| code_rate | input | 2 | Rate select, sampled at the start of each group |
| delay_idx | output | 2 | Delay-factor index of the current pass |
| poly_idx | output | 2 | Check-polynomial index |
| mem_addr | output | 8 | Posterior memory address |
| lane_en | output | 5 | Lane enables: bits 0..3 systematic, bit 4 parity |
| first_pass | output | 1 | First pass of the current check node |
| mem_rd | output | 1 | Posterior memory read strobe |
| mem_wr | output | 1 | Posterior memory write strobe |
| overrun_err | output | 1 | Sticky flag for a dropped strobe |

## Verification
Strobe trains are sent at each of the four rates. This shows whether the parity position follows the latched rate, and whether the lane mask changes only at group starts. One group changes code_rate partway through, which separates a rate sampled per group from a rate sampled on every strobe. Strobes sent during DF0, DF1 and DF2 show whether a busy-time strobe is really dropped: after such a strobe, the next group's parity position must be unchanged. A long run of rate-1/2 groups drives the address through its wrap and the polynomial index through many periods.

// File: rtl/ldcc_ctl_pkg.sv
package ldcc_ctl_pkg;

    // Sequencer states: idle, then one state per delay factor.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DF0  = 2'd1,
        ST_DF1  = 2'd2,
        ST_DF2  = 2'd3
    } node_state_t;

    localparam int RATE_W   = 2;
    localparam int NUM_SYS  = 4;             // systematic lanes X0..X3
    localparam int NUM_LANE = NUM_SYS + 1;   // plus parity lane
    localparam int PHASE_W  = 3;             // position inside a code-bit group

    typedef logic [RATE_W-1:0] rate_t;

endpackage

// File: rtl/ldcc_wrap_counter.sv
module ldcc_wrap_counter #(
    parameter int MODULUS = 3,
    parameter int W       = (MODULUS > 1) ? $clog2(MODULUS) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] value
);

    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (step) begin
            value <= (value == LAST) ? '0 : value + 1'b1;
        end
    end

endmodule

// File: rtl/ldcc_lane_decode.sv
module ldcc_lane_decode
    import ldcc_ctl_pkg::*;
(
    input  rate_t               rate,
    output logic [NUM_LANE-1:0] lane_en
);

    // Systematic lane i is needed when the rate code reaches i.
    for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys
        assign lane_en[i] = (int'(rate) >= i);
    end

    assign lane_en[NUM_SYS] = 1'b1;

endmodule

// File: rtl/ldcc_node_fsm.sv
module ldcc_node_fsm
    import ldcc_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        data_valid,
    input  rate_t       code_rate,
    output rate_t       rate_q,
    output logic [1:0]  delay_idx,
    output logic        node_done,
    output logic        first_pass,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        overrun_err
);

    node_state_t        state_q, state_d;
    logic [PHASE_W-1:0] phase_q;
    rate_t              grp_rate;
    logic               accept, group_last, trigger;

    // Strobes are accepted only while idle.
    assign accept     = data_valid && (state_q == ST_IDLE);
    assign grp_rate   = (phase_q == '0) ? code_rate : rate_q;
    assign group_last = (phase_q == PHASE_W'(grp_rate) + PHASE_W'(1));
    assign trigger    = accept && group_last;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trigger) state_d = ST_DF0;
            ST_DF0:  state_d = ST_DF1;
            ST_DF1:  state_d = ST_DF2;
            ST_DF2:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        delay_idx  = 2'd0;
        node_done  = 1'b0;
        first_pass = 1'b0;
        mem_rd     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DF0: begin
                first_pass = 1'b1;
                mem_rd     = 1'b1;
            end
            ST_DF1: begin
                delay_idx = 2'd1;
                mem_rd    = 1'b1;
            end
            ST_DF2: begin
                delay_idx = 2'd2;
                mem_rd    = 1'b1;
                node_done = 1'b1;
            end
            default: ;
        endcase
    end

    // Group position, rate latch, write strobe and overrun flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q     <= '0;
            rate_q      <= '0;
            mem_wr      <= 1'b0;
            overrun_err <= 1'b0;
        end else begin
            mem_wr <= mem_rd;
            if (data_valid && (state_q != ST_IDLE)) overrun_err <= 1'b1;
            if (accept) begin
                if (phase_q == '0) rate_q <= code_rate;
                phase_q <= group_last ? '0 : phase_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ldcc_proc_ctrl.sv
module ldcc_proc_ctrl
    import ldcc_ctl_pkg::*;
#(
    parameter int MEM_DEPTH = 228,
    parameter int PERIOD    = 3,
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int PW       = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_valid,
    input  logic [1:0]    code_rate,
    output logic [1:0]    delay_idx,
    output logic [PW-1:0] poly_idx,
    output logic [AW-1:0] mem_addr,
    output logic [4:0]    lane_en,
    output logic          first_pass,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          overrun_err
);

    rate_t rate_q;
    logic  node_done;

    ldcc_node_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .data_valid  (data_valid),
        .code_rate   (code_rate),
        .rate_q      (rate_q),
        .delay_idx   (delay_idx),
        .node_done   (node_done),
        .first_pass  (first_pass),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .overrun_err (overrun_err)
    );

    ldcc_wrap_counter #(.MODULUS(PERIOD), .W(PW)) u_poly (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (node_done),
        .value (poly_idx)
    );

    ldcc_wrap_counter #(.MODULUS(MEM_DEPTH), .W(AW)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (node_done),
        .value (mem_addr)
    );

    ldcc_lane_decode u_lanes (
        .rate    (rate_q),
        .lane_en (lane_en)
    );

endmodule

// File: rtl/ldcc_proc_ctrl_chk.sv
module ldcc_proc_ctrl_chk #(
    parameter int DEPTH = 228,
    parameter int AW    = 8,
    parameter int PW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          data_valid,
    input logic [1:0]    delay_idx,
    input logic [PW-1:0] poly_idx,
    input logic [AW-1:0] mem_addr,
    input logic [4:0]    lane_en,
    input logic          first_pass,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          overrun_err
);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !data_valid) |=> !mem_rd);

    a_r3_df0_to_df1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && delay_idx == 2'd0) |=> (mem_rd && delay_idx == 2'd1));

    a_r3_df1_to_df2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && delay_idx == 2'd1) |=> (mem_rd && delay_idx == 2'd2));

    a_r3_df2_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && delay_idx == 2'd2) |=> !mem_rd);

    a_r4_poly_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (poly_idx != $past(poly_idx)) |-> $past(mem_rd && delay_idx == 2'd2));

    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |->
            ((mem_addr == $past(mem_addr) + 1'b1) ||
             (mem_addr == '0 && $past(mem_addr) == AW'(DEPTH - 1))));

    a_r7_parity_lane: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en[4] && $countones(lane_en) >= 2);

    a_r8_first_pass: assert property (@(posedge clk) disable iff (!rst_n)
        first_pass |-> (mem_rd && delay_idx == 2'd0));

    a_r9_wr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    a_r9_no_stray_wr: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> !mem_wr);

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err);

endmodule

bind ldcc_proc_ctrl ldcc_proc_ctrl_chk #(.DEPTH(MEM_DEPTH), .AW(AW), .PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_valid  (data_valid),
    .delay_idx   (delay_idx),
    .poly_idx    (poly_idx),
    .mem_addr    (mem_addr),
    .lane_en     (lane_en),
    .first_pass  (first_pass),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .overrun_err (overrun_err)
);

// File: tb/sim_ldcc_proc_ctrl.sv
`timescale 1ns/1ps
module sim_ldcc_proc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_valid = 1'b0;
    logic [1:0] code_rate = 2'd0;
    logic [1:0] delay_idx;
    logic [1:0] poly_idx;
    logic [7:0] mem_addr;
    logic [4:0] lane_en;
    logic       first_pass, mem_rd, mem_wr, overrun_err;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    ldcc_proc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .data_valid(data_valid), .code_rate(code_rate),
        .delay_idx(delay_idx), .poly_idx(poly_idx), .mem_addr(mem_addr),
        .lane_en(lane_en), .first_pass(first_pass), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .overrun_err(overrun_err)
    );

    // Behavioural reference: node step -1 means idle, else 0..2.
    int m_step = -1, m_phase = 0, m_rate = 0, m_poly = 0, m_addr = 0;
    bit m_err = 0, m_wr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_step = -1; m_phase = 0; m_rate = 0; m_poly = 0; m_addr = 0;
            m_err = 0; m_wr = 0;
        end else begin
            int old_step;
            bit start;
            old_step = m_step;
            start = 0;
            if (data_valid) begin
                if (old_step >= 0) m_err = 1;
                else begin
                    if (m_phase == 0) m_rate = int'(code_rate);
                    if (m_phase == m_rate + 1) begin start = 1; m_phase = 0; end
                    else m_phase++;
                end
            end
            m_wr = (old_step >= 0);
            if (old_step == 2) begin
                m_step = -1;
                m_poly = (m_poly + 1) % 3;
                m_addr = (m_addr + 1) % 228;
            end else if (old_step >= 0) m_step = old_step + 1;
            if (start) m_step = 0;
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic int exp_lanes(int r);
        int m = 16;
        for (int i = 0; i < 4; i++) if (i <= r) m |= (1 << i);
        return m;
    endfunction

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        check("R3 delay_idx", int'(delay_idx), (m_step < 0) ? 0 : m_step);
        check("R4 poly_idx", int'(poly_idx), m_poly);
        check("R5 mem_addr", int'(mem_addr), m_addr);
        check("R7 lane_en", int'(lane_en), exp_lanes(m_rate));
        check("R8 first_pass", int'(first_pass), int'(m_step == 0));
        check("R3 mem_rd", int'(mem_rd), int'(m_step >= 0));
        check("R9 mem_wr", int'(mem_wr), int'(m_wr));
        check("R10 overrun_err", int'(overrun_err), int'(m_err));
        if (cyc == 150000) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic strobe(int r);
        code_rate = 2'(r);
        data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One whole group at rate r, then wait out the check node.
    task automatic group(int r);
        for (int i = 0; i < r + 2; i++) begin
            strobe(r);
            if (i < r + 1) idle(1);
        end
        idle(3);
    endtask

    initial begin
        idle(2);
        // R1: reset values
        check("R1 delay", int'(delay_idx), 0);
        check("R1 poly", int'(poly_idx), 0);
        check("R1 addr", int'(mem_addr), 0);
        check("R1 lanes", int'(lane_en), 5'b10001);
        check("R1 strobes", int'({first_pass, mem_rd, mem_wr, overrun_err}), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: a systematic strobe alone starts nothing
        strobe(0);
        idle(2);
        check("R2 no node after systematic", int'(mem_rd), 0);
        strobe(0);
        check("R3 node starts after parity", int'(mem_rd), 1);
        check("R8 first pass", int'(first_pass), 1);
        idle(3);

        // R6/R7: each rate, parity at the last strobe of the group
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < r + 1; i++) begin strobe(r); idle(1); end
            check("R6 no node before parity", int'(mem_rd), 0);
            check("R7 lane mask", int'(lane_en), exp_lanes(r));
            strobe(r);
            check("R6 node at parity", int'(mem_rd), 1);
            idle(3);
        end

        // R6: rate change inside a group is ignored (group begun at rate 3)
        strobe(3); idle(1);
        strobe(0); idle(1);
        check("R6 mid-group rate ignored", int'(mem_rd), 0);
        strobe(1); idle(1);
        strobe(2); idle(1);
        check("R6 still in group", int'(mem_rd), 0);
        check("R7 mask from group start", int'(lane_en), 5'b11111);
        strobe(0);
        check("R6 parity at fifth strobe", int'(mem_rd), 1);
        idle(3);

        // R10: strobes during DF0, DF1 and DF2 are dropped
        strobe(1); idle(1); strobe(1); idle(1);
        strobe(1);
        strobe(1);
        check("R10 flag set", int'(overrun_err), 1);
        strobe(1);
        strobe(1);
        idle(1);
        group(1);
        check("R10 flag sticky", int'(overrun_err), 1);

        // R4/R5: long run through the address wrap
        for (int n = 0; n < 232; n++) group(0);
        group(2);

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule